// File: doc/BRIEF.md
# Sync-Gated Packet Byte FIFO

This block buffers packet bytes between a radio's bit-level datapath and a host. In receive direction the demodulator pushes bytes and the host pops them. In transmit direction the host pushes bytes and a serializer pops them. The storage holds 64 bytes. A 2-bit length code picks how much of it is in use. A 6-bit threshold code sets the fill level that raises the threshold flag.

In receive, bytes are only accepted while filling is enabled. A mode bit selects how filling is enabled. In the automatic mode, a one-cycle sync-detect pulse starts filling, and filling stays on until the FIFO is flushed. In the host mode, a control bit turns filling on and off directly. The block reports not-empty, full, threshold and a sticky overflow flag. In transmit it also reports whether bits are still waiting to go out.

Both data ports are valid/ready streams, and a beat moves when valid and ready are high at a rising edge. The read side offers data whenever the FIFO holds a byte, and a consumer stalls it by holding `rd_ready` low. The write side cannot hold back a demodulator, so `wr_ready` means that filling is enabled and says nothing about free space. An accepted beat that meets a full FIFO with no pop in the same cycle is dropped, and that drop is recorded as overflow.

Top module: `pkt_fifo_ctrl`

## Requirements
- R1: The length code selects the usable depth: 0 gives 16 bytes, 1 gives 32, 2 gives 48 and 3 gives 64. `full` is 1 exactly when the stored count equals that depth. Bytes leave in the order they were stored.
- R2: In receive (`cfg_dir_tx`=0), `thr_irq` is 1 whenever the stored count is greater than or equal to `cfg_thr`+1. In transmit, `thr_irq` is 0.
- R3: In receive with `cfg_fill_mode`=0, `wr_ready` is 0 after reset and after every flush. It goes to 1 in the cycle after a `sync_det` pulse and stays at 1 until the next flush. Beats offered while it is 0 are not stored.
- R4: In receive with `cfg_fill_mode`=1, `wr_ready` equals `cfg_fill_on`, and `sync_det` has no effect.
- R5: An accepted write beat that arrives while `full` is 1, with no pop in the same cycle, is dropped and sets `overflow`. `overflow` stays at 1 until it is cleared.
- R6: A pulse on `ovf_clr` clears `overflow`, empties the FIFO and, in automatic mode, returns filling to waiting for a sync pulse.
- R7: A push and a pop in the same cycle leave the count unchanged. This includes the case of a full FIFO, and in that case no overflow is raised.
- R8: `rd_valid` and `not_empty` are 1 exactly when the count is non-zero. All flags follow the count register and change in the cycle after the edge that moved it.
- R9: `tx_pending` is 1 in transmit while the FIFO is non-empty or `ser_busy` is 1. Otherwise it is 0.
- R10: A change of the length code empties the FIFO at the next edge, so the count never exceeds the new depth.
- R11: In transmit, `wr_ready` is 1 regardless of the fill mode, the fill control bit and sync pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Usable depth code |
| cfg_thr | input | 6 | Threshold code (level = code+1) |
| cfg_fill_mode | input | 1 | 0: fill starts on sync pulse, 1: host-controlled fill |
| cfg_fill_on | input | 1 | Host fill enable for mode 1 |
| cfg_dir_tx | input | 1 | 0: receive, 1: transmit |
| ovf_clr | input | 1 | Pulse: clear overflow and flush |
| sync_det | input | 1 | One-cycle sync pattern detect pulse |
| ser_busy | input | 1 | Serializer still shifting bits |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Filling enabled |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Byte available |
| rd_ready | input | 1 | Consumer takes byte |
| rd_data | output | 8 | Oldest stored byte |
| thr_irq | output | 1 | Count reached threshold (receive) |
| not_empty | output | 1 | FIFO holds data |
| full | output | 1 | Count equals selected depth |
| overflow | output | 1 | Sticky overflow flag |
| tx_pending | output | 1 | Transmit bits still pending |

## Verification
A write and a read can land on the same edge. On a full FIFO, this pairing decides between a clean exchange and a dropped byte with overflow. The bench holds `rd_ready` high while it pushes into a FIFO that is full at 32 bytes. It then checks that `full` stays at 1, that `overflow` stays at 0 and that the scoreboard still sees every byte in order. It also pushes into a full FIFO with `rd_ready` low and expects overflow, with the dropped byte missing from the later drain.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  typedef enum logic [0:0] {
    FILL_WAIT = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_t;

  function automatic int unsigned max_depth(input int unsigned seg, input int unsigned len_w);
    return seg * (1 << len_w);
  endfunction
endpackage

// File: rtl/pf_store.sv
module pf_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned PTR_W  = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pf_count.sv
module pf_count #(
  parameter int unsigned LEN_W = 2,
  parameter int unsigned SEG   = 16,
  parameter int unsigned CNT_W = 7,
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_code,
  input  logic             push_try,
  input  logic             pop,
  input  logic             clr_req,
  output logic             flush,
  output logic             wr_en,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             overflow
);
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] depth;
  logic [PTR_W-1:0] last_idx;
  logic             len_chg;
  logic             do_pop;
  logic             do_push;
  logic             drop;

  assign depth    = CNT_W'((32'(len_q) + 32'd1) * SEG);
  assign last_idx = PTR_W'(depth - CNT_W'(1));
  assign len_chg  = (len_code != len_q);
  assign flush    = clr_req || len_chg;
  assign full     = (count == depth);
  assign do_pop   = pop && (count != '0) && !flush;
  assign do_push  = push_try && (!full || do_pop) && !flush;
  assign drop     = push_try && full && !do_pop && !flush;
  assign wr_en    = do_push;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] lim);
    return (p == lim) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      count    <= '0;
      wptr     <= '0;
      rptr     <= '0;
      overflow <= 1'b0;
    end else begin
      len_q <= len_code;
      if (flush) begin
        count <= '0;
        wptr  <= '0;
        rptr  <= '0;
        if (clr_req) overflow <= 1'b0;
      end else begin
        if (drop) overflow <= 1'b1;
        if (do_push) wptr <= step(wptr, last_idx);
        if (do_pop)  rptr <= step(rptr, last_idx);
        case ({do_push, do_pop})
          2'b10:   count <= count + CNT_W'(1);
          2'b01:   count <= count - CNT_W'(1);
          default: count <= count;
        endcase
      end
    end
  end

  // R1
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth);

  // R1
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_try && !full && !pop && !flush) |=> (count == $past(count) + CNT_W'(1)));

  // R5
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_try && full && !pop && !flush) |=> (overflow && count == $past(count)));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (count == '0 && !overflow));

  // R7
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_try && pop && count != '0 && !flush) |=> (count == $past(count)));

  // R10
  len_change_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_code != len_q) |=> (count == '0));
endmodule

// File: rtl/pf_fill.sv
module pf_fill
  import pkt_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir_tx,
  input  logic fill_mode,
  input  logic fill_on,
  input  logic sync_det,
  input  logic restart,
  output logic fill_en
);
  fill_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (dir_tx || fill_mode || restart) begin
      state_d = FILL_WAIT;
    end else if (state_q == FILL_WAIT && sync_det) begin
      state_d = FILL_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FILL_WAIT;
    else        state_q <= state_d;
  end

  always_comb begin
    if (dir_tx)         fill_en = 1'b1;
    else if (fill_mode) fill_en = fill_on;
    else                fill_en = (state_q == FILL_RUN);
  end

  // R3
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_tx && !fill_mode && !fill_en && !sync_det) |=> (!fill_en || fill_mode || dir_tx));

  // R3
  sync_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_tx && !fill_mode && sync_det && !restart) |=> (fill_en || fill_mode || dir_tx));
endmodule

// File: rtl/pkt_fifo_ctrl.sv
module pkt_fifo_ctrl
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 2,
  parameter int unsigned THR_W  = 6,
  parameter int unsigned SEG    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [THR_W-1:0]  cfg_thr,
  input  logic              cfg_fill_mode,
  input  logic              cfg_fill_on,
  input  logic              cfg_dir_tx,
  input  logic              ovf_clr,
  input  logic              sync_det,
  input  logic              ser_busy,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              thr_irq,
  output logic              not_empty,
  output logic              full,
  output logic              overflow,
  output logic              tx_pending
);
  localparam int unsigned MAX_D = max_depth(SEG, LEN_W);
  localparam int unsigned PTR_W = $clog2(MAX_D);
  localparam int unsigned CNT_W = $clog2(MAX_D + 1);

  logic             fill_en;
  logic             flush;
  logic             wr_en;
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] thr_lvl;
  logic             push_try, pop;

  assign wr_ready = fill_en;
  assign push_try = wr_valid && fill_en;
  assign rd_valid = (count != '0);
  assign pop      = rd_valid && rd_ready;

  pf_fill u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_tx    (cfg_dir_tx),
    .fill_mode (cfg_fill_mode),
    .fill_on   (cfg_fill_on),
    .sync_det  (sync_det),
    .restart   (flush),
    .fill_en   (fill_en)
  );

  pf_count #(
    .LEN_W (LEN_W),
    .SEG   (SEG),
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_code (cfg_len),
    .push_try (push_try),
    .pop      (pop),
    .clr_req  (ovf_clr),
    .flush    (flush),
    .wr_en    (wr_en),
    .wptr     (wptr),
    .rptr     (rptr),
    .count    (count),
    .full     (full),
    .overflow (overflow)
  );

  pf_store #(
    .DATA_W (DATA_W),
    .DEPTH  (MAX_D),
    .PTR_W  (PTR_W)
  ) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (rd_data)
  );

  assign thr_lvl    = CNT_W'(cfg_thr) + CNT_W'(1);
  assign thr_irq    = !cfg_dir_tx && (count >= thr_lvl);
  assign not_empty  = rd_valid;
  assign tx_pending = cfg_dir_tx && (rd_valid || ser_busy);

  // R9
  tx_pending_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_tx && ser_busy) |-> tx_pending);

  // R2
  thr_tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dir_tx |-> !thr_irq);
endmodule

// File: tb/pkt_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module pkt_fifo_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_len = 2'd0;
  logic [5:0] cfg_thr = 6'd0;
  logic       cfg_fill_mode = 1'b0, cfg_fill_on = 1'b0, cfg_dir_tx = 1'b0;
  logic       ovf_clr = 1'b0, sync_det = 1'b0, ser_busy = 1'b0;
  logic       wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_ready, rd_valid, thr_irq, not_empty, full, overflow, tx_pending;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  pkt_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_thr(cfg_thr),
    .cfg_fill_mode(cfg_fill_mode), .cfg_fill_on(cfg_fill_on), .cfg_dir_tx(cfg_dir_tx),
    .ovf_clr(ovf_clr), .sync_det(sync_det), .ser_busy(ser_busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .thr_irq(thr_irq), .not_empty(not_empty), .full(full),
    .overflow(overflow), .tx_pending(tx_pending)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] q[$];
  bit exp_ready = 1'b0;
  bit exp_ovf = 1'b0;
  int depth = 16;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] d);
    int sz;
    chk(wr_ready == exp_ready, "R3/R4/R11 wr_ready", int'(wr_ready), int'(exp_ready));
    wr_valid = 1'b1;
    wr_data  = d;
    sz = q.size();
    if (exp_ready) begin
      if (sz < depth || (rd_ready && sz > 0)) q.push_back(d);
      else exp_ovf = 1'b1;
    end
    tick;
    wr_valid = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) push_byte(base + 8'(i));
  endtask

  task automatic drain;
    rd_ready = 1'b1;
    while (rd_valid) tick;
    rd_ready = 1'b0;
    chk(q.size() == 0, "R1 drained all expected", q.size(), 0);
    chk(not_empty == 1'b0, "R8 not_empty after drain", int'(not_empty), 0);
  endtask

  task automatic do_clear;
    ovf_clr = 1'b1;
    tick;
    ovf_clr = 1'b0;
    q.delete();
    exp_ovf = 1'b0;
  endtask

  task automatic set_len(input logic [1:0] code);
    cfg_len = code;
    tick;
    q.delete();
    depth = (int'(code) + 1) * 16;
  endtask

  // Scoreboard monitor: the pop decided by rd_valid/rd_ready takes effect at the next edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rd_valid && rd_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected byte", int'(rd_data), -1);
        end else begin
          logic [7:0] e;
          e = q.pop_front();
          chk(rd_data == e, "R1 order", int'(rd_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R8 reset state
    chk(not_empty == 0, "R8 reset not_empty", int'(not_empty), 0);
    chk(full == 0, "R1 reset full", int'(full), 0);
    chk(overflow == 0, "R5 reset overflow", int'(overflow), 0);
    chk(tx_pending == 0, "R9 reset tx_pending", int'(tx_pending), 0);
    chk(wr_ready == 0, "R3 waits for sync after reset", int'(wr_ready), 0);

    // R3: beats before sync are not stored
    cfg_thr = 6'd3;
    exp_ready = 1'b0;
    push_n(3, 8'hA0);
    chk(not_empty == 0, "R3 no store before sync", int'(not_empty), 0);
    sync_det = 1'b1;
    tick;
    sync_det = 1'b0;
    exp_ready = 1'b1;
    chk(wr_ready == 1, "R3 ready after sync", int'(wr_ready), 1);

    // R2 threshold at 4 (code 3)
    push_n(3, 8'h10);
    chk(thr_irq == 0, "R2 below threshold", int'(thr_irq), 0);
    chk(not_empty == 1, "R8 not_empty", int'(not_empty), 1);
    push_byte(8'h13);
    chk(thr_irq == 1, "R2 at threshold", int'(thr_irq), 1);

    // R1 depth 16
    push_n(11, 8'h14);
    chk(full == 0, "R1 not full at 15", int'(full), 0);
    push_byte(8'h1F);
    chk(full == 1, "R1 full at 16", int'(full), 1);
    chk(overflow == 0, "R5 no overflow yet", int'(overflow), 0);
    // R5 drop while full
    push_byte(8'hEE);
    chk(overflow == 1, "R5 overflow on drop", int'(overflow), 1);
    chk(full == 1, "R5 still full", int'(full), 1);
    drain;
    chk(overflow == 1, "R5 overflow sticky", int'(overflow), 1);

    // R6 clear
    push_n(2, 8'h30);
    do_clear;
    exp_ready = 1'b0;
    chk(overflow == 0, "R6 overflow cleared", int'(overflow), 0);
    chk(not_empty == 0, "R6 flushed", int'(not_empty), 0);
    chk(wr_ready == 0, "R6 back to waiting", int'(wr_ready), 0);

    // R4 host-controlled fill
    cfg_fill_mode = 1'b1;
    cfg_fill_on = 1'b0;
    sync_det = 1'b1;
    tick;
    sync_det = 1'b0;
    tick;
    chk(wr_ready == 0, "R4 sync ignored in host mode", int'(wr_ready), 0);
    push_byte(8'h55);
    chk(not_empty == 0, "R4 no store when off", int'(not_empty), 0);
    cfg_fill_on = 1'b1;
    exp_ready = 1'b1;
    tick;
    chk(wr_ready == 1, "R4 ready follows control", int'(wr_ready), 1);

    // R10 depth change flushes
    push_n(5, 8'h40);
    set_len(2'd1);
    chk(not_empty == 0, "R10 flushed on length change", int'(not_empty), 0);

    // R1 depth 32, R7 exchange on full
    push_n(31, 8'h50);
    chk(full == 0, "R1 not full at 31", int'(full), 0);
    push_byte(8'h6F);
    chk(full == 1, "R1 full at 32", int'(full), 1);
    rd_ready = 1'b1;
    push_byte(8'h70);
    push_byte(8'h71);
    rd_ready = 1'b0;
    chk(full == 1, "R7 full kept on push+pop", int'(full), 1);
    chk(overflow == 0, "R7 no overflow on push+pop", int'(overflow), 0);
    drain;

    // R1 depth 48
    set_len(2'd2);
    push_n(47, 8'h80);
    chk(full == 0, "R1 not full at 47", int'(full), 0);
    push_byte(8'hAF);
    chk(full == 1, "R1 full at 48", int'(full), 1);

    // R1/R2 depth 64 with threshold 64
    set_len(2'd3);
    cfg_thr = 6'd63;
    push_n(63, 8'h00);
    chk(thr_irq == 0, "R2 below 64", int'(thr_irq), 0);
    chk(full == 0, "R1 not full at 63", int'(full), 0);
    push_byte(8'h3F);
    chk(thr_irq == 1, "R2 at 64", int'(thr_irq), 1);
    chk(full == 1, "R1 full at 64", int'(full), 1);
    drain;

    // R11/R9 transmit
    cfg_dir_tx = 1'b1;
    cfg_fill_mode = 1'b0;
    cfg_fill_on = 1'b0;
    cfg_thr = 6'd0;
    tick;
    chk(wr_ready == 1, "R11 tx always ready", int'(wr_ready), 1);
    chk(tx_pending == 0, "R9 idle tx", int'(tx_pending), 0);
    push_n(2, 8'hC0);
    chk(thr_irq == 0, "R2 no threshold in tx", int'(thr_irq), 0);
    chk(tx_pending == 1, "R9 pending with data", int'(tx_pending), 1);
    drain;
    chk(tx_pending == 0, "R9 done when empty", int'(tx_pending), 0);
    ser_busy = 1'b1;
    tick;
    chk(tx_pending == 1, "R9 pending while shifting", int'(tx_pending), 1);
    ser_busy = 1'b0;
    tick;
    chk(tx_pending == 0, "R9 all bits sent", int'(tx_pending), 0);
    chk(overflow == exp_ovf, "R5 final overflow", int'(overflow), int'(exp_ovf));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule